// File: doc/BRIEF.md
# PHY Status Transfer Sender

This block moves status information from the physical layer to the link layer. It uses a 2-bit control bus and a 2-bit data bus, and it puts one 2-bit symbol on the bus each clock. Event flags come in as pulses and are collected in a pending set. A register readback request, or the automatic node-address report that follows self-identification, fills a single register slot. When the interface is idle and work is pending, the block starts a transfer. The transfer is short (the flags only) when the slot is empty, and long (flags, register address and register data) when the slot holds a register.

A received packet may cut a transfer off. When that happens the block releases the control bus in the same cycle. Flag bits count as delivered in the cycle that carries them. A register counts as delivered only when its last data symbol has gone out. After an interruption the block starts again only if flags are still pending or the register slot is still full. When a register has been fully delivered, a one-cycle pulse tells the request tracker.

Top module: `phy_status_tx`

## Requirements
- R1: While reset is held and in the first cycle after it, `ctl` and `d` are 00 and `reg_done` is 0.
- R2: A transfer starts only in the cycle after one in which `if_idle` is 1, `pkt_rx` is 0 and work is pending. Every cycle of a transfer drives `ctl` = 01. The only other value ever driven on `ctl` is 00 (not transferring).
- R3: With only flags pending, the transfer lasts 2 cycles. `d` carries flag bits [3:2] and then [1:0]. The more significant bit of each pair is on `d[1]`.
- R4: With the register slot full, the transfer lasts 8 cycles. It carries a 16-bit word, most significant bit first: {flags[3:0], address[3:0], data[7:0]}.
- R5: In any cycle where `pkt_rx` is 1, `ctl` and `d` are 00. A transfer in progress is abandoned.
- R6: Flag bits driven before an interruption are cleared. Flag bits not yet driven stay pending and go out in the retried transfer.
- R7: An interrupted register transfer is retried as a full long transfer. `reg_done` pulses for exactly one cycle, in the cycle after the eighth symbol, and only then.
- R8: If an interruption leaves no flags pending and the slot empty, no transfer follows.
- R9: At least one cycle with `ctl` = 00 separates any two transfers.
- R10: Flags raised while a transfer is running are OR-accumulated. They go out in a later transfer.
- R11: A readback request that arrives while the slot is full is ignored. The register first captured is the one sent.
- R12: `selfid_done` queues a register transfer whose address is the parameter PHYID_ADDR and whose data is `node_id`. If a readback request arrives in the same cycle, the readback goes out first and the node-address report follows it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| flag_set | input | FLAG_W | Per-flag event pulses |
| rd_req | input | 1 | Register readback request |
| rd_addr | input | ADDR_W | Address of the register read |
| rd_data | input | DATA_W | Contents of the register read |
| selfid_done | input | 1 | Self-identification finished pulse |
| node_id | input | DATA_W | Node-address register contents |
| if_idle | input | 1 | Link interface is idle |
| pkt_rx | input | 1 | Packet reception starting; interrupts a transfer |
| ctl | output | 2 | Control bus: 00 idle, 01 status |
| d | output | SYM_W | Status data symbol |
| reg_done | output | 1 | One-cycle pulse: register fully delivered |

## Verification
The bench uses the default parameters: 4 flag bits, 4 address bits, 8 data bits, 2-bit symbols and PHYID_ADDR of 0. With these values, short and long frames of 2 and 8 cycles can be observed in full. Interruptions at chosen symbol positions exercise each delivery rule. Random flag and register patterns are checked against frames built in the bench. Directed cases cover the gating by `if_idle`, flags raised during the last symbol, a rejected second readback, and the ordering of a readback against the node-address report.

// File: rtl/pst_pkg.sv
package pst_pkg;
  typedef enum logic [0:0] {
    PST_IDLE = 1'b0,
    PST_SEND = 1'b1
  } pst_state_e;

  localparam logic [1:0] CTL_NONE   = 2'b00;
  localparam logic [1:0] CTL_STATUS = 2'b01;
endpackage

// File: rtl/pst_flag_acc.sv
// Pending flag set: new events OR in, delivered bits drop out.
module pst_flag_acc #(
  parameter int FLAG_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] set_i,
  input  logic [FLAG_W-1:0] clr_i,
  output logic [FLAG_W-1:0] pend_o
);
  logic [FLAG_W-1:0] pend_q, pend_n;
  logic              upd;

  always_comb begin
    pend_n = (pend_q & ~clr_i) | set_i;
    upd    = (|set_i) | (|clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   pend_q <= '0;
    else if (upd) pend_q <= pend_n;
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/pst_reg_slot.sv
// Single register slot: readback first, self-ID report queued behind it.
module pst_reg_slot #(
  parameter int              ADDR_W     = 4,
  parameter int              DATA_W     = 8,
  parameter logic [ADDR_W-1:0] PHYID_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              sid_i,
  input  logic [DATA_W-1:0] node_id_i,
  input  logic              fin_i,
  output logic              pend_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              pend_q, pend_n, sid_q, sid_n, load;
  logic [ADDR_W-1:0] addr_q, addr_n;
  logic [DATA_W-1:0] data_q, data_n;

  always_comb begin
    pend_n = pend_q;
    addr_n = addr_q;
    data_n = data_q;
    sid_n  = sid_q | sid_i;
    load   = 1'b0;
    if (fin_i) begin
      pend_n = 1'b0;
    end else if (!pend_q) begin
      if (rd_req_i) begin
        pend_n = 1'b1;
        addr_n = rd_addr_i;
        data_n = rd_data_i;
        load   = 1'b1;
      end else if (sid_n) begin
        pend_n = 1'b1;
        addr_n = PHYID_ADDR;
        data_n = node_id_i;
        sid_n  = 1'b0;
        load   = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      sid_q  <= 1'b0;
    end else begin
      pend_q <= pend_n;
      sid_q  <= sid_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
    end else if (load) begin
      addr_q <= addr_n;
      data_q <= data_n;
    end
  end

  assign pend_o = pend_q;
  assign addr_o = addr_q;
  assign data_o = data_q;
endmodule

// File: rtl/pst_seq.sv
// Transfer sequencer and serializer.
module pst_seq
  import pst_pkg::*;
#(
  parameter int FLAG_W = 4,
  parameter int ADDR_W = 4,
  parameter int DATA_W = 8,
  parameter int SYM_W  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flags_i,
  input  logic              reg_pend_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_data_i,
  input  logic              if_idle_i,
  input  logic              pkt_rx_i,
  output logic [1:0]        ctl_o,
  output logic [SYM_W-1:0]  d_o,
  output logic [FLAG_W-1:0] flag_clr_o,
  output logic              reg_fin_o,
  output logic              reg_done_o
);
  localparam int FRAME_W   = FLAG_W + ADDR_W + DATA_W;
  localparam int SHORT_CYC = FLAG_W / SYM_W;
  localparam int LONG_CYC  = FRAME_W / SYM_W;
  localparam int CNT_W     = (LONG_CYC > 1) ? $clog2(LONG_CYC) : 1;
  localparam logic [CNT_W-1:0] SHORT_LAST = CNT_W'(SHORT_CYC - 1);
  localparam logic [CNT_W-1:0] LONG_LAST  = CNT_W'(LONG_CYC - 1);

  pst_state_e        st_q, st_n;
  logic [CNT_W-1:0]  cnt_q, cnt_n;
  logic              long_q, long_n;
  logic              done_q;
  logic              work, start, fire, last;
  logic [FRAME_W-1:0] frame, shifted;

  always_comb begin
    work    = (|flags_i) | reg_pend_i;
    start   = (st_q == PST_IDLE) && if_idle_i && !pkt_rx_i && work;
    fire    = (st_q == PST_SEND) && !pkt_rx_i;
    last    = cnt_q == (long_q ? LONG_LAST : SHORT_LAST);
    frame   = {flags_i, reg_addr_i, reg_data_i};
    shifted = frame << (cnt_q * SYM_W);
  end

  // next-state logic
  always_comb begin
    st_n   = st_q;
    cnt_n  = cnt_q;
    long_n = long_q;
    case (st_q)
      PST_IDLE: if (start) begin
        st_n   = PST_SEND;
        cnt_n  = '0;
        long_n = reg_pend_i;
      end
      PST_SEND: begin
        if (pkt_rx_i || last) st_n = PST_IDLE;
        else                  cnt_n = cnt_q + 1'b1;
      end
      default: st_n = PST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= PST_IDLE;
      cnt_q  <= '0;
      long_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_n;
      cnt_q  <= cnt_n;
      long_q <= long_n;
      done_q <= reg_fin_o;
    end
  end

  // flag bits are delivered in the cycle that drives them
  for (genvar k = 0; k < SHORT_CYC; k++) begin : g_clr
    assign flag_clr_o[FLAG_W-1-SYM_W*k -: SYM_W] =
      {SYM_W{fire && (cnt_q == CNT_W'(k))}};
  end

  assign reg_fin_o  = fire && long_q && (cnt_q == LONG_LAST);
  assign reg_done_o = done_q;
  assign ctl_o      = fire ? CTL_STATUS : CTL_NONE;
  assign d_o        = fire ? shifted[FRAME_W-1 -: SYM_W] : '0;
endmodule

// File: rtl/phy_status_tx.sv
module phy_status_tx #(
  parameter int                FLAG_W     = 4,
  parameter int                ADDR_W     = 4,
  parameter int                DATA_W     = 8,
  parameter int                SYM_W      = 2,
  parameter logic [ADDR_W-1:0] PHYID_ADDR = '0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [FLAG_W-1:0] flag_set,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [DATA_W-1:0] rd_data,
  input  logic              selfid_done,
  input  logic [DATA_W-1:0] node_id,
  input  logic              if_idle,
  input  logic              pkt_rx,
  output logic [1:0]        ctl,
  output logic [SYM_W-1:0]  d,
  output logic              reg_done
);
  logic [FLAG_W-1:0] flags, flag_clr;
  logic              reg_pend, reg_fin;
  logic [ADDR_W-1:0] reg_addr;
  logic [DATA_W-1:0] reg_data;

  pst_flag_acc #(.FLAG_W(FLAG_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .set_i(flag_set), .clr_i(flag_clr), .pend_o(flags)
  );

  pst_reg_slot #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .PHYID_ADDR(PHYID_ADDR)) u_slot (
    .clk(clk), .rst_n(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rd_data_i(rd_data), .sid_i(selfid_done), .node_id_i(node_id),
    .fin_i(reg_fin), .pend_o(reg_pend), .addr_o(reg_addr), .data_o(reg_data)
  );

  pst_seq #(.FLAG_W(FLAG_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYM_W(SYM_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .flags_i(flags), .reg_pend_i(reg_pend),
    .reg_addr_i(reg_addr), .reg_data_i(reg_data), .if_idle_i(if_idle),
    .pkt_rx_i(pkt_rx), .ctl_o(ctl), .d_o(d), .flag_clr_o(flag_clr),
    .reg_fin_o(reg_fin), .reg_done_o(reg_done)
  );
endmodule

// File: rtl/phy_status_tx_chk.sv
module phy_status_tx_chk #(
  parameter int SYM_W = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             if_idle,
  input logic             pkt_rx,
  input logic [1:0]       ctl,
  input logic [SYM_W-1:0] d,
  input logic             reg_done
);
  // R2
  ctl_code_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl == 2'b00) || (ctl == 2'b01));

  // R2
  start_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ctl[0]) |-> ($past(if_idle) && !$past(pkt_rx)));

  // R5
  release_on_packet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_rx |-> (ctl == 2'b00 && d == '0));

  // R7
  done_after_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(reg_done) |-> ($past(ctl) == 2'b01));

  // R7
  done_single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_done |=> !reg_done);

  // R9
  gap_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    reg_done |-> (ctl == 2'b00));
endmodule

bind phy_status_tx phy_status_tx_chk #(.SYM_W(SYM_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .if_idle(if_idle), .pkt_rx(pkt_rx),
  .ctl(ctl), .d(d), .reg_done(reg_done)
);

// File: tb/tb_phy_status_tx.sv
`timescale 1ns/1ps
module tb_phy_status_tx;
  localparam logic [3:0] PHYID = 4'h0;

  logic       clk, rst_n;
  logic [3:0] flag_set;
  logic       rd_req;
  logic [3:0] rd_addr;
  logic [7:0] rd_data;
  logic       selfid_done;
  logic [7:0] node_id;
  logic       if_idle, pkt_rx;
  logic [1:0] ctl;
  logic [1:0] d;
  logic       reg_done;

  int nchk = 0;
  int nerr = 0;

  phy_status_tx dut (
    .clk(clk), .rst_n(rst_n), .flag_set(flag_set), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_data(rd_data), .selfid_done(selfid_done),
    .node_id(node_id), .if_idle(if_idle), .pkt_rx(pkt_rx),
    .ctl(ctl), .d(d), .reg_done(reg_done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  function automatic logic [1:0] exp_sym(input logic [15:0] fr, input int c);
    logic [15:0] s;
    s = fr << (2 * c);
    return s[15:14];
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #2;
  endtask

  task automatic wait_status(input string req);
    bit found = 0;
    for (int i = 0; i < 40 && !found; i++) begin
      #1;
      if (ctl == 2'b01) found = 1;
      else tick();
    end
    chk(found, req, 0, 1);
  endtask

  // Called in the first status cycle. intr < 0 means no interruption.
  task automatic check_frame(input logic [15:0] fr, input int len, input int intr, input string req);
    for (int c = 0; c < len; c++) begin
      if (c == intr) begin
        pkt_rx = 1'b1;
        #1;
        chk(ctl == 2'b00 && d == 2'b00, "R5", {ctl, d}, 0);
        tick();
        pkt_rx = 1'b0;
        #1;
        chk(reg_done == 1'b0, "R7", reg_done, 0);
        return;
      end
      #1;
      chk(ctl == 2'b01, req, ctl, 1);
      chk(d == exp_sym(fr, c), req, d, exp_sym(fr, c));
      tick();
    end
    #1;
    chk(ctl == 2'b00, "R9", ctl, 0);
    if (len == 8) chk(reg_done == 1'b1, "R7", reg_done, 1);
    tick();
    #1;
    chk(reg_done == 1'b0, "R7", reg_done, 0);
  endtask

  initial begin
    #150000;
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end

  initial begin
    void'($urandom(32'hC0FFEE));
    rst_n = 1'b0; flag_set = '0; rd_req = 0; rd_addr = '0; rd_data = '0;
    selfid_done = 0; node_id = 8'h2C; if_idle = 1'b1; pkt_rx = 1'b0;
    #1;
    chk(ctl == 0 && d == 0 && reg_done == 0, "R1", {ctl, d, reg_done}, 0);
    repeat (3) tick();
    rst_n = 1'b1;
    #1;
    chk(ctl == 0 && d == 0 && reg_done == 0, "R1", {ctl, d, reg_done}, 0);
    tick();

    // R2: held off while interface busy, starts the cycle after idle
    if_idle = 1'b0; flag_set = 4'b0100; tick(); flag_set = '0;
    for (int i = 0; i < 5; i++) begin
      #1; chk(ctl == 2'b00, "R2", ctl, 0); tick();
    end
    if_idle = 1'b1;
    #1; chk(ctl == 2'b00, "R2", ctl, 0); tick();
    #1; chk(ctl == 2'b01, "R2", ctl, 1);
    check_frame(16'h4000, 2, -1, "R3");

    // R6: interrupted after the first flag symbol; the rest is retried
    flag_set = 4'b1111; tick(); flag_set = '0;
    wait_status("R6");
    check_frame(16'hF000, 2, 1, "R6");
    tick();
    #1; chk(ctl == 2'b01, "R6", ctl, 1);
    check_frame(16'h3000, 2, -1, "R6");

    // R8: nothing left after interruption, no retry
    flag_set = 4'b1000; tick(); flag_set = '0;
    wait_status("R8");
    check_frame(16'h8000, 2, 1, "R8");
    for (int i = 0; i < 6; i++) begin
      #1; chk(ctl == 2'b00, "R8", ctl, 0); tick();
    end

    // R7: register interrupted mid-data, retried whole
    rd_req = 1'b1; rd_addr = 4'h5; rd_data = 8'hA5; tick(); rd_req = 1'b0;
    wait_status("R7");
    check_frame(16'h05A5, 8, 5, "R7");
    wait_status("R7");
    check_frame(16'h05A5, 8, -1, "R4");

    // R10 and R9: flag raised during the final symbol goes out next
    flag_set = 4'b0010; tick(); flag_set = '0;
    wait_status("R10");
    #1; chk(d == 2'b00, "R3", d, 0); tick();
    flag_set = 4'b0001;
    #1; chk(ctl == 2'b01 && d == 2'b10, "R3", {ctl, d}, 6); tick();
    flag_set = '0;
    #1; chk(ctl == 2'b00, "R9", ctl, 0); tick();
    #1; chk(ctl == 2'b01 && d == 2'b00, "R10", {ctl, d}, 4); tick();
    #1; chk(ctl == 2'b01 && d == 2'b01, "R10", {ctl, d}, 5); tick();
    repeat (2) tick();

    // R11: second readback while slot is full is ignored
    if_idle = 1'b0;
    rd_req = 1'b1; rd_addr = 4'h3; rd_data = 8'h3C; tick();
    rd_addr = 4'h9; rd_data = 8'h99; tick();
    rd_req = 1'b0; if_idle = 1'b1;
    wait_status("R11");
    check_frame(16'h033C, 8, -1, "R11");
    repeat (3) tick();
    #1; chk(ctl == 2'b00, "R11", ctl, 0);

    // R12: readback and self-ID together; readback first
    if_idle = 1'b0;
    rd_req = 1'b1; rd_addr = 4'h7; rd_data = 8'h71; selfid_done = 1'b1; tick();
    rd_req = 1'b0; selfid_done = 1'b0; if_idle = 1'b1;
    wait_status("R12");
    check_frame(16'h0771, 8, -1, "R12");
    wait_status("R12");
    check_frame({4'h0, PHYID, 8'h2C}, 8, -1, "R12");
    repeat (3) tick();

    // random frames (R3, R4)
    for (int it = 0; it < 40; it++) begin
      logic [3:0] f, a;
      logic [7:0] dt;
      bit ur;
      f  = 4'($urandom % 16);
      a  = 4'($urandom % 16);
      dt = 8'($urandom % 256);
      ur = bit'($urandom % 2);
      if (!ur && f == 0) f = 4'h1;
      flag_set = f; rd_req = ur; rd_addr = a; rd_data = dt;
      tick();
      flag_set = '0; rd_req = 1'b0;
      wait_status(ur ? "R4" : "R3");
      if (ur) check_frame({f, a, dt}, 8, -1, "R4");
      else    check_frame({f, 12'h000}, 2, -1, "R3");
      repeat (2) tick();
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nerr);
    $finish;
  end
endmodule